// File: doc/BRIEF.md
# Shared SRAM Bus Arbiter for a 6502-Style CPU

This block lets a 6502-style processor and a second bus master, such as a video or I/O engine, share one asynchronous SRAM. The processor clock is never stopped or stretched. To take the memory away from the CPU, the arbiter first pulls the CPU's ready input low. It waits until it sees that the CPU has halted at a rising phase-2 edge. It then drops the CPU's bus-enable input so that the CPU's address, data and read/write lines float. After a turnaround gap it raises the grant to the second master. Handing the bus back repeats these steps in reverse order.

The arbiter also produces the SRAM chip select and write strobe. The chip select depends only on the address decode and on which master owns the bus, never on the clock. A CPU write strobe is limited to the phase-2 high half of the cycle. A second-master write strobe follows that master's own strobe. A compatibility option covers the older processor, which ignores ready during write cycles. A separate wait input reuses the ready path to add wait states for a slow device without any handover.

Top module: `shram_arbiter`

## Requirements
- R1: After reset the CPU owns the bus: ready is high, bus enable is high and grant is low.
- R2: While the CPU owns the bus, a high request drives ready low one clock later. Grant is never high while ready is high.
- R3: Once ready is low, the first rising phase-2 edge that counts as a halt confirmation drives bus enable low on the next clock.
- R4: Bus enable stays low for TURN clocks before grant rises. Grant and bus enable are never high together.
- R5: With NMOS_COMPAT=1, a rising phase-2 edge with cpu_rw=0 (write) does not confirm the halt. Only a rising edge with cpu_rw=1 (read) does.
- R6: When the request drops, grant falls one clock later. Bus enable rises TURN clocks after that, and ready rises one clock after bus enable.
- R7: A request raised during the return sequence does not cut it short. The sequence completes, ready is high for one clock, and only then does a new handover start.
- R8: Chip select (active low) is asserted when the CPU drives the bus and its address lies in the RAM window (the top AW-RAM_AW bits equal those of RAM_BASE), or when grant is high. It does not depend on phase-2.
- R9: A CPU write (cpu_rw=0) to the RAM window drives the SRAM write strobe low only while phi2 is high and the CPU drives the bus.
- R10: While grant is high, the SRAM write strobe equals m2_we_n.
- R11: slow_wait high lowers ready while the CPU owns the bus. Bus enable stays high and no grant is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock, faster than phase-2 |
| rst_n | input | 1 | Active-low synchronous reset |
| phi2 | input | 1 | CPU phase-2 level, synchronous to clk |
| cpu_addr | input | AW | CPU address bus |
| cpu_rw | input | 1 | CPU read/write, 1 = read |
| cpu_rdy | output | 1 | CPU ready input, low halts the CPU |
| cpu_be | output | 1 | CPU bus enable, low floats the CPU bus |
| slow_wait | input | 1 | Wait-state request from a slow device |
| m2_req | input | 1 | Bus request from the second master |
| m2_gnt | output | 1 | Bus grant to the second master |
| m2_we_n | input | 1 | Second-master write strobe, active low |
| sram_ce_n | output | 1 | SRAM chip select, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |

## Verification
The bench builds two copies side by side. One uses NMOS_COMPAT=1 and TURN=2, the other NMOS_COMPAT=0 and TURN=1. Both see the same stream of write cycles during a request, so the two halt-confirmation rules can be compared on the same stimulus. The two-clock turnaround on the first copy makes the gaps between bus-enable and grant edges long enough to count, so an off-by-one in either direction shows up. A request raised in the middle of the return sequence exercises the rule that a new request waits until the sequence completes.

// File: rtl/shr_pkg.sv
package shr_pkg;
   typedef enum logic [2:0] {
      ST_CPU   = 3'd0,
      ST_HALT  = 3'd1,
      ST_FLOAT = 3'd2,
      ST_M2    = 3'd3,
      ST_REL   = 3'd4,
      ST_BEON  = 3'd5
   } shr_state_e;
endpackage

// File: rtl/shr_phase_edge.sv
module shr_phase_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic phi2,
   output logic rise
);
   logic phi2_q;

   always_ff @(posedge clk) begin
      if (!rst_n) phi2_q <= 1'b0;
      else        phi2_q <= phi2;
   end

   assign rise = phi2 & ~phi2_q;
endmodule

// File: rtl/shr_handover_fsm.sv
module shr_handover_fsm
   import shr_pkg::*;
#(
   parameter int NMOS_COMPAT = 1,
   parameter int TURN        = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rise,
   input  logic       cpu_rw,
   input  logic       m2_req,
   output shr_state_e state
);
   localparam int CW = $clog2(TURN + 1);
   localparam logic [CW-1:0] LAST = CW'(TURN - 1);

   logic          confirm;
   logic [CW-1:0] cnt;
   shr_state_e    nxt;

   generate
      if (NMOS_COMPAT != 0) begin : g_nmos
         assign confirm = rise & cpu_rw;
      end else begin : g_cmos
         assign confirm = rise;
      end
   endgenerate

   always_comb begin
      nxt = state;
      unique case (state)
         ST_CPU:   if (m2_req)      nxt = ST_HALT;
         ST_HALT:  if (confirm)     nxt = ST_FLOAT;
         ST_FLOAT: if (cnt == LAST) nxt = ST_M2;
         ST_M2:    if (!m2_req)     nxt = ST_REL;
         ST_REL:   if (cnt == LAST) nxt = ST_BEON;
         ST_BEON:                   nxt = ST_CPU;
         default:                   nxt = ST_CPU;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_CPU;
         cnt   <= '0;
      end else begin
         state <= nxt;
         if (nxt != state) cnt <= '0;
         else if (state == ST_FLOAT || state == ST_REL) cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/shr_bus_ctl.sv
module shr_bus_ctl
   import shr_pkg::*;
#(
   parameter int              AW       = 16,
   parameter int              RAM_AW   = 15,
   parameter logic [AW-1:0]   RAM_BASE = '0
) (
   input  shr_state_e    state,
   input  logic [AW-1:0] cpu_addr,
   input  logic          cpu_rw,
   input  logic          phi2,
   input  logic          slow_wait,
   input  logic          m2_we_n,
   output logic          cpu_rdy,
   output logic          cpu_be,
   output logic          m2_gnt,
   output logic          sram_ce_n,
   output logic          sram_we_n
);
   localparam int TAGW = AW - RAM_AW;

   logic hit;
   logic cpu_own;

   generate
      if (TAGW > 0) begin : g_dec
         assign hit = cpu_addr[AW-1 -: TAGW] == RAM_BASE[AW-1 -: TAGW];
      end else begin : g_full
         assign hit = 1'b1;
      end
   endgenerate

   assign cpu_own   = (state == ST_CPU) || (state == ST_HALT) || (state == ST_BEON);
   assign cpu_be    = cpu_own;
   assign cpu_rdy   = (state == ST_CPU) && !slow_wait;
   assign m2_gnt    = (state == ST_M2);
   assign sram_ce_n = !((cpu_own && hit) || m2_gnt);
   assign sram_we_n = !((cpu_own && hit && !cpu_rw && phi2) || (m2_gnt && !m2_we_n));
endmodule

// File: rtl/shram_arbiter.sv
module shram_arbiter
   import shr_pkg::*;
#(
   parameter int            AW          = 16,
   parameter int            RAM_AW      = 15,
   parameter logic [AW-1:0] RAM_BASE    = '0,
   parameter int            NMOS_COMPAT = 1,
   parameter int            TURN        = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          phi2,
   input  logic [AW-1:0] cpu_addr,
   input  logic          cpu_rw,
   output logic          cpu_rdy,
   output logic          cpu_be,
   input  logic          slow_wait,
   input  logic          m2_req,
   output logic          m2_gnt,
   input  logic          m2_we_n,
   output logic          sram_ce_n,
   output logic          sram_we_n
);
   generate
      if (TURN < 1) begin : g_bad_turn
         $error("shram_arbiter: TURN must be at least 1");
      end
      if (RAM_AW > AW || RAM_AW < 1) begin : g_bad_ram
         $error("shram_arbiter: RAM_AW must lie in 1..AW");
      end
      if (NMOS_COMPAT != 0 && NMOS_COMPAT != 1) begin : g_bad_mode
         $error("shram_arbiter: NMOS_COMPAT must be 0 or 1");
      end
   endgenerate

   logic       rise;
   shr_state_e state;

   shr_phase_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .phi2  (phi2),
      .rise  (rise)
   );

   shr_handover_fsm #(
      .NMOS_COMPAT (NMOS_COMPAT),
      .TURN        (TURN)
   ) u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .rise   (rise),
      .cpu_rw (cpu_rw),
      .m2_req (m2_req),
      .state  (state)
   );

   shr_bus_ctl #(
      .AW       (AW),
      .RAM_AW   (RAM_AW),
      .RAM_BASE (RAM_BASE)
   ) u_bus (
      .state     (state),
      .cpu_addr  (cpu_addr),
      .cpu_rw    (cpu_rw),
      .phi2      (phi2),
      .slow_wait (slow_wait),
      .m2_we_n   (m2_we_n),
      .cpu_rdy   (cpu_rdy),
      .cpu_be    (cpu_be),
      .m2_gnt    (m2_gnt),
      .sram_ce_n (sram_ce_n),
      .sram_we_n (sram_we_n)
   );
endmodule

// File: rtl/shr_arb_checker.sv
module shr_arb_checker (
   input logic clk,
   input logic rst_n,
   input logic phi2,
   input logic cpu_rdy,
   input logic cpu_be,
   input logic m2_gnt,
   input logic sram_ce_n,
   input logic sram_we_n
);
   // R4
   no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_be && m2_gnt));

   // R4
   grant_after_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(m2_gnt) |-> !$past(cpu_be));

   // R2
   grant_needs_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m2_gnt |-> !cpu_rdy);

   // R6
   be_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_be) |-> !$past(m2_gnt));

   // R6
   ready_after_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_rdy) |-> $past(cpu_be));

   // R8
   idle_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_be && !m2_gnt) |-> sram_ce_n);

   // R9
   write_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> !sram_ce_n);

   // R9
   cpu_write_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_be && !sram_we_n) |-> phi2);
endmodule

bind shram_arbiter shr_arb_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .phi2      (phi2),
   .cpu_rdy   (cpu_rdy),
   .cpu_be    (cpu_be),
   .m2_gnt    (m2_gnt),
   .sram_ce_n (sram_ce_n),
   .sram_we_n (sram_we_n)
);

// File: tb/shram_arbiter_tb.sv
`timescale 1ns/1ps
module shram_arbiter_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        phi2 = 1'b0;
   logic [15:0] cpu_addr = 16'h0100;
   logic        cpu_rw = 1'b1;
   logic        slow_wait = 1'b0;
   logic        m2_req = 1'b0;
   logic        m2_we_n = 1'b1;
   logic        rdy [2];
   logic        be  [2];
   logic        gnt [2];
   logic        ce_n[2];
   logic        we_n[2];

   int errors = 0;
   int checks = 0;
   int pcnt   = 0;
   bit rand_bus = 1'b0;
   int rw_mode  = 1;   // 0 write, 1 read, 2 random
   bit done     = 1'b0;

   always #5 clk = ~clk;

   shram_arbiter #(.NMOS_COMPAT(1), .TURN(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .phi2(phi2), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
      .cpu_rdy(rdy[0]), .cpu_be(be[0]), .slow_wait(slow_wait), .m2_req(m2_req),
      .m2_gnt(gnt[0]), .m2_we_n(m2_we_n), .sram_ce_n(ce_n[0]), .sram_we_n(we_n[0]));

   shram_arbiter #(.NMOS_COMPAT(0), .TURN(1)) u_dut_alt (
      .clk(clk), .rst_n(rst_n), .phi2(phi2), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
      .cpu_rdy(rdy[1]), .cpu_be(be[1]), .slow_wait(slow_wait), .m2_req(m2_req),
      .m2_gnt(gnt[1]), .m2_we_n(m2_we_n), .sram_ce_n(ce_n[1]), .sram_we_n(we_n[1]));

   // Reference model: 0 cpu, 1 waiting for halt, 2 floating, 3 granted,
   // 4 releasing, 5 bus enable back with ready still low
   int mst [2] = '{0, 0};
   int mcnt[2] = '{0, 0};
   int turn_p[2] = '{2, 1};
   bit nmos_p[2] = '{1'b1, 1'b0};
   bit mprev = 1'b0;

   always @(posedge clk) begin
      bit edge_seen;
      edge_seen = phi2 && !mprev;
      for (int i = 0; i < 2; i++) begin
         if (!rst_n) begin
            mst[i] = 0; mcnt[i] = 0;
         end else begin
            case (mst[i])
               0: if (m2_req) mst[i] = 1;
               1: if (edge_seen && (!nmos_p[i] || cpu_rw)) begin mst[i] = 2; mcnt[i] = 0; end
               2: if (mcnt[i] == turn_p[i] - 1) mst[i] = 3; else mcnt[i]++;
               3: if (!m2_req) begin mst[i] = 4; mcnt[i] = 0; end
               4: if (mcnt[i] == turn_p[i] - 1) mst[i] = 5; else mcnt[i]++;
               default: mst[i] = 0;
            endcase
         end
      end
      mprev = rst_n ? phi2 : 1'b0;
   end

   task automatic expect_bit(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      for (int i = 0; i < 2; i++) begin
         bit own, hit, e_rdy, e_gnt, e_ce, e_we;
         own   = (mst[i] == 0) || (mst[i] == 1) || (mst[i] == 5);
         hit   = (cpu_addr[15] == 1'b0);
         e_rdy = (mst[i] == 0) && !slow_wait;
         e_gnt = (mst[i] == 3);
         e_ce  = (own && hit) || e_gnt;
         e_we  = (own && hit && !cpu_rw && phi2) || (e_gnt && !m2_we_n);
         expect_bit($sformatf("R2 ready inst%0d", i), rdy[i], e_rdy);
         expect_bit($sformatf("R3 bus enable inst%0d", i), be[i], own);
         expect_bit($sformatf("R4 grant inst%0d", i), gnt[i], e_gnt);
         expect_bit($sformatf("R8 chip select inst%0d", i), ce_n[i], !e_ce);
         expect_bit($sformatf("R9 write strobe inst%0d", i), we_n[i], !e_we);
      end
   endtask

   task automatic step();
      @(negedge clk);
      pcnt++;
      phi2 = ((pcnt % 6) >= 3);
      if (rand_bus) begin
         cpu_addr = 16'($urandom);
         cpu_rw   = (rw_mode == 2) ? 1'($urandom) : (rw_mode == 1);
      end
      #2;
      if (rst_n) compare();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int n;
      bit found;
      repeat (4) step();
      rst_n = 1'b1;
      step();
      // R1 reset ownership
      for (int i = 0; i < 2; i++) begin
         expect_bit("R1 ready after reset", rdy[i], 1'b1);
         expect_bit("R1 bus enable after reset", be[i], 1'b1);
         expect_bit("R1 grant after reset", gnt[i], 1'b0);
      end

      // R11 wait state without handover
      slow_wait = 1'b1;
      step(); step();
      expect_bit("R11 ready low on wait", rdy[0], 1'b0);
      expect_bit("R11 bus enable kept", be[0], 1'b1);
      expect_bit("R11 no grant", gnt[0], 1'b0);
      slow_wait = 1'b0;
      step();
      expect_bit("R11 ready back", rdy[0], 1'b1);

      // R8 / R9 chip select and write strobe against phase-2
      cpu_addr = 16'h1234; cpu_rw = 1'b0;
      n = 0;
      do begin step(); n++; end while (!phi2 && n < 8);
      expect_bit("R9 cpu write strobe in phi2 high", we_n[0], 1'b0);
      expect_bit("R8 select in phi2 high", ce_n[0], 1'b0);
      n = 0;
      do begin step(); n++; end while (phi2 && n < 8);
      expect_bit("R9 no cpu write strobe in phi2 low", we_n[0], 1'b1);
      expect_bit("R8 select not gated by phi2", ce_n[0], 1'b0);
      cpu_addr = 16'h9000;
      step();
      expect_bit("R8 select off outside window", ce_n[0], 1'b1);

      rand_bus = 1'b1; rw_mode = 2;
      repeat (30) step();

      // R5 writes do not confirm the halt in compatibility mode
      rw_mode = 0; m2_req = 1'b1;
      repeat (14) step();
      expect_bit("R5 compat copy still driving", be[0], 1'b1);
      expect_bit("R5 compat copy no grant", gnt[0], 1'b0);
      expect_bit("R4 other copy granted", gnt[1], 1'b1);

      // R3 a read confirms the halt
      rw_mode = 1;
      found = 1'b0;
      for (int k = 0; k < 30 && !found; k++) begin
         step();
         if (!be[0]) found = 1'b1;
      end
      expect_bit("R3 bus enable dropped after read halt", found, 1'b1);
      n = 0;
      while (!gnt[0] && n < 10) begin step(); n++; end
      expect_bit("R4 turnaround before grant", (n == 2), 1'b1);

      // R10 second-master write strobe
      m2_we_n = 1'b0;
      step();
      expect_bit("R10 strobe follows master", we_n[0], 1'b0);
      expect_bit("R10 strobe follows master alt", we_n[1], 1'b0);
      expect_bit("R8 select while granted", ce_n[0], 1'b0);
      m2_we_n = 1'b1;
      step();
      expect_bit("R10 strobe released", we_n[0], 1'b1);

      // R6 return order, R7 request held during return
      m2_req = 1'b0;
      step();
      expect_bit("R6 grant drops first", gnt[0], 1'b0);
      m2_req = 1'b1;
      n = 0;
      while (!be[0] && n < 10) begin step(); n++; end
      expect_bit("R6 turnaround before bus enable", (n == 2), 1'b1);
      expect_bit("R6 ready still low with bus enable", rdy[0], 1'b0);
      step();
      expect_bit("R6 ready after bus enable", rdy[0], 1'b1);
      step();
      expect_bit("R7 held request starts new handover", rdy[0], 1'b0);
      expect_bit("R7 held request no early grant", gnt[0], 1'b0);

      m2_req = 1'b0; rw_mode = 2;
      repeat (60) step();
      finish_run();
   end
endmodule